// File: doc/BRIEF.md
# Dual-Read Register File

This block holds the working registers of a small load/store processor: eight 16-bit entries behind one write port and two read ports. Three 3-bit addresses come with each instruction. The first address always drives read port A. The second read port shows either the second or the third address, as a control bit selects. On a clock edge with the write enable high, a value is written to the entry named by the third address.

The value written is taken from a four-way selector in front of the file. Its sources are the incremented program counter, the ALU result, memory read data and the current program counter, which lets an interrupt save its return address. A second control bit sends the write to the fixed exception-pointer entry, register 6, in place of the third address. The top entry has no storage and always reads as zero.

An active-low reset clears the stored entries. It takes effect at once and is released in step with the clock.

Top module: `dual_read_regfile`

## Requirements
- R1: Register 7 always reads as zero on both read ports, and a write addressed to it changes no register.
- R2: Read port A shows the register addressed by `ra_addr` combinationally, in the same cycle the address is applied.
- R3: When `rb_use_rc` is 0, read port B shows the register addressed by `rb_addr`. When it is 1, port B shows the register addressed by `rc_addr`.
- R4: When `wr_to_exc` is 0, the write target is the register addressed by `rc_addr`. When it is 1, the target is register 6 and `rc_addr` is ignored for the write.
- R5: A register changes only on a rising clock edge while `wr_en` is 1. In every other cycle all registers keep their values.
- R6: The written value is chosen by `wd_src`: 0 selects `pc_inc`, 1 selects `alu_res`, 2 selects `mem_rdata` and 3 selects `pc_cur`.
- R7: A read of the register being written in the same cycle returns the old value. The new value appears only after the clock edge, with no write-through bypass.
- R8: Driving `rst_n` low clears registers 0 to 6 to zero at once, without waiting for a clock edge. Writes resume two clock edges after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ra_addr | input | 3 | Register address for read port A |
| rb_addr | input | 3 | Register address for read port B when `rb_use_rc` is 0 |
| rc_addr | input | 3 | Write address; also read by port B when `rb_use_rc` is 1 |
| rb_use_rc | input | 1 | Selects `rc_addr` instead of `rb_addr` for read port B |
| wr_to_exc | input | 1 | Sends the write to register 6 instead of `rc_addr` |
| wr_en | input | 1 | Write enable |
| wd_src | input | 2 | Write-data source select |
| pc_inc | input | 16 | Incremented program counter (source 0) |
| alu_res | input | 16 | ALU result (source 1) |
| mem_rdata | input | 16 | Memory read data (source 2) |
| pc_cur | input | 16 | Current program counter (source 3) |
| rd_a | output | 16 | Read port A data |
| rd_b | output | 16 | Read port B data |

## Verification
The assertions take the select and address inputs to be settled before each rising edge. They also take writes to be held off until the internal reset has been released. The bench changes every input half a period away from the rising edge and keeps `wr_en` low during reset and for the release window that follows. Its table feeds four different values to the four write-data sources in each step, so a wrong source selection shows up as a wrong value at a read port.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  // Write-data source codes; the encoding is visible at the wd_src port.
  typedef enum logic [1:0] {
    WD_PC_INC = 2'd0,
    WD_ALU    = 2'd1,
    WD_MEM    = 2'd2,
    WD_PC_CUR = 2'd3
  } wd_src_e;
endpackage

// File: rtl/rf_wdata_sel.sv
module rf_wdata_sel
  import regfile_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] pc_inc_i,
  input  logic [DATA_W-1:0] alu_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] pc_cur_i,
  output logic [DATA_W-1:0] data_o
);
  wd_src_e src;
  assign src = wd_src_e'(sel_i);

  // R6: four-way selection of the value to be written
  always_comb begin
    unique case (src)
      WD_PC_INC: data_o = pc_inc_i;
      WD_ALU:    data_o = alu_i;
      WD_MEM:    data_o = mem_i;
      default:   data_o = pc_cur_i;
    endcase
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs_o
);
  localparam int NREG     = 1 << ADDR_W;
  localparam int ZERO_IDX = NREG - 1;

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_entry
      if (i == ZERO_IDX) begin : g_zero
        // R1: top entry has no storage
        assign regs_o[i] = '0;
      end else begin : g_store
        logic              load;
        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] q_nxt;

        // R5: entry loads only when enabled and addressed
        always_comb begin
          load  = wr_en_i && (wr_addr_i == ADDR_W'(i));
          q_nxt = load ? wr_data_i : q;
        end

        // R8: asynchronous clear
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= q_nxt;
        end

        assign regs_o[i] = q;
      end
    end
  endgenerate
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  output logic [DATA_W-1:0]                  data_o
);
  // R2, R7: purely combinational view of stored state, no bypass
  always_comb data_o = regs_i[addr_i];
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ra_addr,
  input  logic [ADDR_W-1:0] rb_addr,
  input  logic [ADDR_W-1:0] rc_addr,
  input  logic              rb_use_rc,
  input  logic              wr_to_exc,
  input  logic              wr_en,
  input  logic [1:0]        wd_src,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] pc_cur,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  localparam int NREG    = 1 << ADDR_W;
  localparam int EXC_IDX = NREG - 2;

  // Reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [DATA_W-1:0]             wr_data;
  logic [ADDR_W-1:0]             wr_addr;
  logic [ADDR_W-1:0]             b_addr;
  logic [NREG-1:0][DATA_W-1:0]   regs;

  // R4: write target redirection; R3: port B address choice
  always_comb begin
    wr_addr = wr_to_exc ? ADDR_W'(EXC_IDX) : rc_addr;
    b_addr  = rb_use_rc ? rc_addr : rb_addr;
  end

  rf_wdata_sel #(.DATA_W(DATA_W)) u_wsel (
    .sel_i    (wd_src),
    .pc_inc_i (pc_inc),
    .alu_i    (alu_res),
    .mem_i    (mem_rdata),
    .pc_cur_i (pc_cur),
    .data_o   (wr_data)
  );

  rf_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .regs_o    (regs)
  );

  rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .regs_i (regs),
    .addr_i (ra_addr),
    .data_o (rd_a)
  );

  rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .regs_i (regs),
    .addr_i (b_addr),
    .data_o (rd_b)
  );
endmodule

// File: rtl/dual_read_regfile_chk.sv
module dual_read_regfile_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ra_addr,
  input logic [ADDR_W-1:0] rb_addr,
  input logic [ADDR_W-1:0] rc_addr,
  input logic              rb_use_rc,
  input logic              wr_to_exc,
  input logic              wr_en,
  input logic [1:0]        wd_src,
  input logic [DATA_W-1:0] pc_inc,
  input logic [DATA_W-1:0] alu_res,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] pc_cur,
  input logic [DATA_W-1:0] rd_a,
  input logic [DATA_W-1:0] rd_b
);
  localparam logic [ADDR_W-1:0] ZERO_A = ADDR_W'((1 << ADDR_W) - 1);
  localparam logic [ADDR_W-1:0] EXC_A  = ADDR_W'((1 << ADDR_W) - 2);

  logic [DATA_W-1:0] exp_wd;
  always_comb begin
    case (wd_src)
      2'd0:    exp_wd = pc_inc;
      2'd1:    exp_wd = alu_res;
      2'd2:    exp_wd = mem_rdata;
      default: exp_wd = pc_cur;
    endcase
  end

  a_r1_zero_reg_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == ZERO_A) |-> (rd_a == '0));

  a_r3_b_follows_rc: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_use_rc && rc_addr == ra_addr) |-> (rd_b == rd_a));

  a_r3_b_follows_rb: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_use_rc && rb_addr == ra_addr) |-> (rd_b == rd_a));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (ra_addr != $past(ra_addr)) || (rd_a == $past(rd_a)));

  a_r4_exc_target: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_to_exc) |=> (ra_addr != EXC_A) || (rd_a == $past(exp_wd)));

  a_r4_rc_target: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_to_exc && rc_addr != ZERO_A)
      |=> (ra_addr != $past(rc_addr)) || (rd_a == $past(exp_wd)));
endmodule

bind dual_read_regfile dual_read_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ra_addr   (ra_addr),
  .rb_addr   (rb_addr),
  .rc_addr   (rc_addr),
  .rb_use_rc (rb_use_rc),
  .wr_to_exc (wr_to_exc),
  .wr_en     (wr_en),
  .wd_src    (wd_src),
  .pc_inc    (pc_inc),
  .alu_res   (alu_res),
  .mem_rdata (mem_rdata),
  .pc_cur    (pc_cur),
  .rd_a      (rd_a),
  .rd_b      (rd_b)
);

// File: tb/dual_read_regfile_bench.sv
module dual_read_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  ra_addr, rb_addr, rc_addr;
  logic        rb_use_rc, wr_to_exc, wr_en;
  logic [1:0]  wd_src;
  logic [15:0] pc_inc, alu_res, mem_rdata, pc_cur;
  logic [15:0] rd_a, rd_b;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] model [8];

  always #2 clk = ~clk;

  dual_read_regfile u_dual_read_regfile (
    .clk(clk), .rst_n(rst_n), .ra_addr(ra_addr), .rb_addr(rb_addr),
    .rc_addr(rc_addr), .rb_use_rc(rb_use_rc), .wr_to_exc(wr_to_exc),
    .wr_en(wr_en), .wd_src(wd_src), .pc_inc(pc_inc), .alu_res(alu_res),
    .mem_rdata(mem_rdata), .pc_cur(pc_cur), .rd_a(rd_a), .rd_b(rd_b)
  );

  // {wr_en, wr_to_exc, wd_src, rc, ra, rb, rb_use_rc, base}
  localparam int NVEC = 12;
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1,1'b0,2'd1,3'd0,3'd0,3'd1,1'b0,16'h1000}, // R6 alu into r0; R7 old read
    {1'b1,1'b0,2'd0,3'd1,3'd0,3'd1,1'b0,16'h2000}, // R6 pc_inc into r1; R2 read r0
    {1'b1,1'b0,2'd2,3'd2,3'd1,3'd5,1'b1,16'h3000}, // R6 mem into r2; R3 B uses rc
    {1'b1,1'b0,2'd3,3'd3,3'd2,3'd3,1'b0,16'h4000}, // R6 pc_cur into r3
    {1'b1,1'b1,2'd1,3'd5,3'd3,3'd5,1'b1,16'h5000}, // R4 redirected to r6
    {1'b0,1'b0,2'd1,3'd4,3'd6,3'd5,1'b0,16'h6000}, // R5 no write
    {1'b1,1'b0,2'd1,3'd7,3'd7,3'd4,1'b0,16'h7000}, // R1 write to r7
    {1'b0,1'b0,2'd0,3'd2,3'd7,3'd6,1'b0,16'h0000}, // R1 r7 reads zero
    {1'b1,1'b0,2'd2,3'd4,3'd4,3'd4,1'b1,16'h8000}, // R7 same-reg read old
    {1'b0,1'b0,2'd0,3'd7,3'd4,3'd0,1'b0,16'h0000}, // R3 B uses rb
    {1'b1,1'b1,2'd3,3'd0,3'd5,3'd6,1'b0,16'h9000}, // R4 r6 overwrite, r0 kept
    {1'b0,1'b0,2'd0,3'd3,3'd6,3'd0,1'b1,16'h0000}  // R3 B via rc=r3
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_to_exc = 1'b0; rb_use_rc = 1'b0;
    wd_src = 2'd0; ra_addr = 3'd0; rb_addr = 3'd0; rc_addr = 3'd0;
    pc_inc = '0; alu_res = '0; mem_rdata = '0; pc_cur = '0;
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset state of every entry through both ports
    for (int k = 0; k < 8; k++) begin
      ra_addr = 3'(k); rb_addr = 3'(7 - k);
      #1;
      check("R8 reset port A", rd_a, 16'h0);
      check("R8 reset port B", rd_b, 16'h0);
      @(negedge clk);
    end

    // Table walk against the reference model
    for (int s = 0; s < NVEC; s++) begin
      logic [15:0] base, wv;
      logic [2:0]  tgt;
      {wr_en, wr_to_exc, wd_src, rc_addr, ra_addr, rb_addr, rb_use_rc, base} = VEC[s];
      pc_inc = base + 16'd1; alu_res = base + 16'd2;
      mem_rdata = base + 16'd3; pc_cur = base + 16'd4;
      #1;
      check("R2 port A", rd_a, model[ra_addr]);
      check("R3 port B", rd_b, model[rb_use_rc ? rc_addr : rb_addr]);
      wv  = (wd_src == 2'd0) ? pc_inc : (wd_src == 2'd1) ? alu_res :
            (wd_src == 2'd2) ? mem_rdata : pc_cur;
      tgt = wr_to_exc ? 3'd6 : rc_addr;
      @(posedge clk);
      if (wr_en && tgt != 3'd7) model[tgt] = wv;
      @(negedge clk);
    end

    // R7: new value visible after the edge
    wr_en = 1'b0; ra_addr = 3'd4; rb_use_rc = 1'b0; rb_addr = 3'd6;
    #1;
    check("R7 after edge", rd_a, 16'h8003);
    check("R4 r6 from pc_cur", rd_b, 16'h9004);
    ra_addr = 3'd5;
    #1;
    check("R4 rc ignored when redirected", rd_a, 16'h0);

    // R8: asynchronous clear mid-run, before any clock edge
    @(negedge clk);
    ra_addr = 3'd3; rb_addr = 3'd6;
    rst_n = 1'b0;
    #1;
    check("R8 async clear A", rd_a, 16'h0);
    check("R8 async clear B", rd_b, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; wr_to_exc = 1'b0; rc_addr = 3'd3; wd_src = 2'd2; mem_rdata = 16'hBEEF;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R8 writes resume", rd_a, 16'hBEEF);
    check("R5 r6 untouched", rd_b, 16'h0);

    finish_run();
  end
endmodule